// File: doc/BRIEF.md
# Streaming Vector Adder with Register-Polled Results

This block adds two operand streams element by element under the control of a host that sees it only through a bank of 64-bit control and status registers. The host writes an element count, then writes the start register. The block then takes one operand from each of two valid/ready input streams on every cycle it is allowed to, and forms their unsigned sum. No output stream exists. Each sum is parked in a result data register with a valid flag beside it. The host polls the flag, reads the data, and that read frees the datapath for the next pair.

Completion is visible two ways. A status word carries busy and done bits. A finish counter counts completed runs and clears itself when the host reads it. Back-pressure on the input streams has two rules. An input is offered ready only while the other input is valid, so the two operands always transfer together. Both readies stay low while the block is idle or while an unread result is parked. Register accesses are single-cycle strobes. Read data is combinational on the address, and the side effects of a read take place at the clock edge that ends the strobe cycle. Reset is synchronous and active high.

Top module: `csr_vadd_top`

## Requirements
- R1: After reset the status word, finish counter, result valid flag and both stream readies are all zero.
- R2: Register map on byte addresses: 0x00 status (bit 0 busy, bit 1 done), 0x08 start (reads 0), 0x30 finish count in bits [31:0], 0x80 holding the count in [31:0] and result bits [31:0] in [63:32], 0x88 holding result bits [63:32] in [31:0] and the valid flag at bit 32, 0x90 reading 0. Other addresses read 0, and writes to the status word change nothing.
- R3: A write to 0x08 with bit 0 set, while idle, yields one internal start pulse. Busy reads 1 from the second cycle after the write cycle. A write with bit 0 clear does nothing.
- R4: A start write while a run is active or a start pulse is pending is ignored: the run in progress ends after its own count.
- R5: a_ready is high only when b_valid is high, b_ready only when a_valid is high, and either only while busy with no unread result. A pair is consumed on a cycle where both valids and both readies are high.
- R6: Each result is the 33-bit unsigned sum of the two 32-bit operands, zero-extended to 64 bits.
- R7: While the valid flag is set, no pair is accepted and the result data holds. A read of 0x80 clears the flag at the end of that cycle.
- R8: On the edge that consumes the last pair of a run, busy clears and done sets. An accepted start clears done.
- R9: A count of zero finishes at the edge after the start pulse: done sets and the finish counter increments, with no pair accepted.
- R10: The finish counter increments once per completed run. A read of 0x30 returns the current value and clears it.
- R11: If a read of 0x30 falls on the same cycle as a completion, the read returns the old value and the counter then holds 1.
- R12: Writes to 0x80 load the count from bits [31:0]. The count is sampled only by the start pulse, so changing it mid-run does not alter the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe (triggers read side effects) |
| csr_addr | input | 8 | Register byte address |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Register read data, combinational on csr_addr |
| a_valid | input | 1 | Operand A stream valid |
| a_ready | output | 1 | Operand A stream ready |
| a_data | input | 32 | Operand A value |
| b_valid | input | 1 | Operand B stream valid |
| b_ready | output | 1 | Operand B stream ready |
| b_data | input | 32 | Operand B value |

## Verification
Assertions watch the per-cycle rules on every clock:
- the gating of each ready by the opposite valid and by the busy and unread-result state;
- the sum appearing after a transfer;
- the result holding until it is read, and the read clearing the flag;
- the exclusion of busy and done;
- the finish counter's increment, clear and collision arithmetic.

The bench scenarios cover what depends on a sequence of host accesses:
- the register layout;
- the exact cycle in which busy appears after a start;
- start and count writes ignored mid-run;
- the zero-count run;
- a completion landing on a counter read;
- a one-sided stream that must not be consumed;
- a full 256-element run compared element by element.

// File: rtl/csr_vadd_pkg.sv
package csr_vadd_pkg;
  localparam int unsigned WORD_W = 64;
  localparam logic [7:0] OFS_STATUS = 8'h00;
  localparam logic [7:0] OFS_START  = 8'h08;
  localparam logic [7:0] OFS_FINISH = 8'h30;
  localparam logic [7:0] OFS_ARG    = 8'h80;
  localparam int unsigned STAT_BUSY = 0;
  localparam int unsigned STAT_DONE = 1;

  typedef struct packed {
    logic start_req;
    logic count_wr;
    logic res_rd;
    logic fin_rd;
  } csr_strobe_t;
endpackage

// File: rtl/csr_vadd_decode.sv
module csr_vadd_decode
  import csr_vadd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              start_bit,
  output csr_strobe_t       stb
);
  logic hit_start, hit_arg, hit_fin;

  assign hit_start = (csr_addr == ADDR_W'(OFS_START));
  assign hit_arg   = (csr_addr == ADDR_W'(OFS_ARG));
  assign hit_fin   = (csr_addr == ADDR_W'(OFS_FINISH));

  always_comb begin
    stb           = '0;
    stb.start_req = csr_wr && hit_start && start_bit;
    stb.count_wr  = csr_wr && hit_arg;
    stb.res_rd    = csr_rd && hit_arg;
    stb.fin_rd    = csr_rd && hit_fin;
  end
endmodule

// File: rtl/csr_vadd_seq.sv
module csr_vadd_seq #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic             count_wr,
  input  logic [CNT_W-1:0] count_in,
  input  logic             fire,
  output logic [CNT_W-1:0] count_q,
  output logic             busy,
  output logic             done,
  output logic             complete
);
  logic             start_p;
  logic             start_take;
  logic [CNT_W-1:0] remaining;
  logic             last_pair;
  logic             zero_run;

  assign start_take = start_req && !busy && !start_p;
  assign last_pair  = fire && (remaining == CNT_W'(1));
  assign zero_run   = start_p && (count_q == '0);
  assign complete   = zero_run || last_pair;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (count_wr) begin
      count_q <= count_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_p   <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      remaining <= '0;
    end else begin
      start_p <= start_take;
      if (start_p) begin
        remaining <= count_q;
        busy      <= (count_q != '0);
        done      <= (count_q == '0);
      end else if (fire) begin
        remaining <= remaining - CNT_W'(1);
        if (last_pair) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/csr_vadd_lane.sv
module csr_vadd_lane #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RES_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              res_rd,
  input  logic              a_valid,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_valid,
  input  logic [DATA_W-1:0] b_data,
  output logic              a_ready,
  output logic              b_ready,
  output logic              fire,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data
);
  localparam int unsigned SUM_W = DATA_W + 1;

  logic             open_slot;
  logic [SUM_W-1:0] sum;

  assign open_slot = busy && !res_valid;
  assign a_ready   = open_slot && b_valid;
  assign b_ready   = open_slot && a_valid;
  assign fire      = open_slot && a_valid && b_valid;
  assign sum       = {1'b0, a_data} + {1'b0, b_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (fire) begin
      res_valid <= 1'b1;
      res_data  <= RES_W'(sum);
    end else if (res_rd) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/csr_vadd_fincnt.sv
module csr_vadd_fincnt #(
  parameter int unsigned FIN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [FIN_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (clr) begin
      value <= inc ? FIN_W'(1) : '0;
    end else if (inc) begin
      value <= value + FIN_W'(1);
    end
  end
endmodule

// File: rtl/csr_vadd_top.sv
module csr_vadd_top
  import csr_vadd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned FIN_W  = 32,
  parameter int unsigned RES_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [WORD_W-1:0] csr_wdata,
  output logic [WORD_W-1:0] csr_rdata,
  input  logic              a_valid,
  output logic              a_ready,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_valid,
  output logic              b_ready,
  input  logic [DATA_W-1:0] b_data
);
  localparam int unsigned STRIDE    = WORD_W / 8;
  localparam int unsigned ARG_BITS  = CNT_W + 2 * RES_W;
  localparam int unsigned ARG_WORDS = (ARG_BITS + WORD_W - 1) / WORD_W;

  csr_strobe_t             stb;
  logic                    busy, done, fire, fin_inc;
  logic                    res_rd, fin_rd;
  logic                    res_valid;
  logic [RES_W-1:0]        res_data;
  logic [CNT_W-1:0]        count_q;
  logic [FIN_W-1:0]        fin_cnt;
  logic [1:0]              status;
  logic [ARG_WORDS*WORD_W-1:0] arg_region;

  assign res_rd = stb.res_rd;
  assign fin_rd = stb.fin_rd;

  csr_vadd_decode #(.ADDR_W(ADDR_W)) u_decode (
    .csr_wr    (csr_wr),
    .csr_rd    (csr_rd),
    .csr_addr  (csr_addr),
    .start_bit (csr_wdata[0]),
    .stb       (stb)
  );

  csr_vadd_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_req (stb.start_req),
    .count_wr  (stb.count_wr),
    .count_in  (csr_wdata[CNT_W-1:0]),
    .fire      (fire),
    .count_q   (count_q),
    .busy      (busy),
    .done      (done),
    .complete  (fin_inc)
  );

  csr_vadd_lane #(.DATA_W(DATA_W), .RES_W(RES_W)) u_lane (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .res_rd    (res_rd),
    .a_valid   (a_valid),
    .a_data    (a_data),
    .b_valid   (b_valid),
    .b_data    (b_data),
    .a_ready   (a_ready),
    .b_ready   (b_ready),
    .fire      (fire),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  csr_vadd_fincnt #(.FIN_W(FIN_W)) u_fin (
    .clk   (clk),
    .rst   (rst),
    .inc   (fin_inc),
    .clr   (fin_rd),
    .value (fin_cnt)
  );

  always_comb begin
    status            = '0;
    status[STAT_BUSY] = busy;
    status[STAT_DONE] = done;
  end

  assign arg_region = (ARG_WORDS*WORD_W)'({RES_W'(res_valid), res_data, count_q});

  always_comb begin
    csr_rdata = '0;
    if (csr_addr == ADDR_W'(OFS_STATUS)) begin
      csr_rdata = WORD_W'(status);
    end else if (csr_addr == ADDR_W'(OFS_FINISH)) begin
      csr_rdata = WORD_W'(fin_cnt);
    end
    for (int k = 0; k < int'(ARG_WORDS); k++) begin
      if (csr_addr == ADDR_W'(int'(OFS_ARG) + k * int'(STRIDE))) begin
        csr_rdata = arg_region[k*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/csr_vadd_chk.sv
module csr_vadd_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FIN_W  = 32,
  parameter int unsigned RES_W  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              a_valid,
  input logic              a_ready,
  input logic [DATA_W-1:0] a_data,
  input logic              b_valid,
  input logic              b_ready,
  input logic [DATA_W-1:0] b_data,
  input logic              busy,
  input logic              done,
  input logic              res_valid,
  input logic [RES_W-1:0]  res_data,
  input logic              res_rd,
  input logic              fin_rd,
  input logic              fin_inc,
  input logic [FIN_W-1:0]  fin_cnt
);
  // R5
  ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (a_ready || b_ready) |-> (busy && !res_valid));
  // R5
  a_cross_chk: assert property (@(posedge clk) disable iff (rst)
    a_ready |-> b_valid);
  // R5
  b_cross_chk: assert property (@(posedge clk) disable iff (rst)
    b_ready |-> a_valid);
  // R6
  sum_chk: assert property (@(posedge clk) disable iff (rst)
    (a_valid && a_ready) |=>
      (res_valid && res_data == (RES_W'($past(a_data)) + RES_W'($past(b_data)))));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_rd) |=> (res_valid && $stable(res_data)));
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_rd) |=> !res_valid);
  // R8
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  // R10
  fin_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (fin_inc && !fin_rd) |=> (fin_cnt == $past(fin_cnt) + FIN_W'(1)));
  // R10
  fin_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (fin_rd && !fin_inc) |=> (fin_cnt == '0));
  // R11
  fin_both_chk: assert property (@(posedge clk) disable iff (rst)
    (fin_rd && fin_inc) |=> (fin_cnt == FIN_W'(1)));
endmodule

bind csr_vadd_top csr_vadd_chk #(
  .DATA_W(DATA_W), .FIN_W(FIN_W), .RES_W(RES_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .a_valid   (a_valid),
  .a_ready   (a_ready),
  .a_data    (a_data),
  .b_valid   (b_valid),
  .b_ready   (b_ready),
  .b_data    (b_data),
  .busy      (busy),
  .done      (done),
  .res_valid (res_valid),
  .res_data  (res_data),
  .res_rd    (res_rd),
  .fin_rd    (fin_rd),
  .fin_inc   (fin_inc),
  .fin_cnt   (fin_cnt)
);

// File: tb/csr_vadd_top_tb.sv
module csr_vadd_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_wr = 1'b0, csr_rd = 1'b0;
  logic [7:0]  csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        a_valid = 1'b0, b_valid = 1'b0;
  logic        a_ready, b_ready;
  logic [31:0] a_data = '0, b_data = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit en_a = 1, en_b = 1;

  logic [31:0] qa[$];
  logic [31:0] qb[$];
  logic [63:0] exp_q[$];

  // behavioural reference state
  bit          m_busy = 0, m_done = 0, m_startp = 0, m_valid = 0;
  logic [31:0] m_count = '0, m_rem = '0, m_fin = '0;
  logic [63:0] m_data = '0;

  always #5 clk = ~clk;

  csr_vadd_top u_dut (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [63:0] exp_rd(input logic [7:0] ad);
    case (ad)
      8'h00:   return {62'd0, m_done, m_busy};
      8'h30:   return {32'd0, m_fin};
      8'h80:   return {m_data[31:0], m_count};
      8'h88:   return {31'd0, m_valid, m_data[63:32]};
      default: return 64'd0;
    endcase
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    bit rdy, fire, frd, rrd, stw, inc;
    if (rst) begin
      m_busy = 0; m_done = 0; m_startp = 0; m_valid = 0;
      m_count = '0; m_rem = '0; m_fin = '0; m_data = '0;
    end else begin
      rdy  = m_busy && !m_valid;
      fire = rdy && a_valid && b_valid;
      frd  = csr_rd && csr_addr == 8'h30;
      rrd  = csr_rd && csr_addr == 8'h80;
      stw  = csr_wr && csr_addr == 8'h08 && csr_wdata[0] && !m_busy && !m_startp;
      inc  = 0;
      if (m_startp) begin
        if (m_count == 0) begin m_done = 1; inc = 1; end
        else begin m_busy = 1; m_done = 0; m_rem = m_count; end
      end else if (fire) begin
        m_rem = m_rem - 1;
        if (m_rem == 0) begin m_busy = 0; m_done = 1; inc = 1; end
      end
      if (fire) begin
        m_valid = 1;
        m_data = 64'({1'b0, a_data} + {1'b0, b_data});
        void'(qa.pop_front());
        void'(qb.pop_front());
      end else if (rrd) begin
        m_valid = 0;
      end
      m_startp = stw;
      if (csr_wr && csr_addr == 8'h80) m_count = csr_wdata[31:0];
      m_fin = frd ? (inc ? 32'd1 : 32'd0) : m_fin + (inc ? 32'd1 : 32'd0);
    end
  end

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (!rst && !finished) begin
      chk("R5 a_ready", {63'd0, a_ready}, {63'd0, m_busy && !m_valid && b_valid});
      chk("R5 b_ready", {63'd0, b_ready}, {63'd0, m_busy && !m_valid && a_valid});
      if (csr_rd) chk("R2 rdata", csr_rdata, exp_rd(csr_addr));
    end
  end

  // stream sources
  always @(negedge clk) begin
    a_valid = en_a && qa.size() > 0;
    a_data  = (qa.size() > 0) ? qa[0] : 32'd0;
    b_valid = en_b && qb.size() > 0;
    b_data  = (qb.size() > 0) ? qb[0] : 32'd0;
  end

  task automatic wr(input logic [7:0] ad, input logic [63:0] d);
    csr_wr = 1; csr_addr = ad; csr_wdata = d;
    @(negedge clk);
    csr_wr = 0;
  endtask

  task automatic rd(input logic [7:0] ad, output logic [63:0] v);
    csr_rd = 1; csr_addr = ad;
    #1 v = csr_rdata;
    @(negedge clk);
    csr_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_pair(input logic [31:0] a, input logic [31:0] b);
    qa.push_back(a);
    qb.push_back(b);
    exp_q.push_back({31'd0, {1'b0, a} + {1'b0, b}});
  endtask

  task automatic take(input string tag);
    logic [63:0] w, got;
    w = '0;
    while (!w[32]) rd(8'h88, w);
    got[63:32] = w[31:0];
    rd(8'h80, w);
    got[31:0] = w[63:32];
    chk(tag, got, exp_q.pop_front());
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [31:0] x;
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(8'h00, v); chk("R1 status", v, 64'd0);
    rd(8'h30, v); chk("R1 finish", v, 64'd0);
    rd(8'h88, v); chk("R1 valid", v, 64'd0);
    chk("R1 ready", {62'd0, a_ready, b_ready}, 64'd0);

    // R12 count load, upper write bits ignored
    wr(8'h80, 64'hFFFF_FFFF_0000_0003);
    rd(8'h80, v); chk("R12 count", v, 64'h0000_0000_0000_0003);
    // R2 status write ignored, start reads 0, unmapped reads 0
    wr(8'h00, 64'h3);
    rd(8'h00, v); chk("R2 status write", v, 64'd0);
    rd(8'h08, v); chk("R2 start read", v, 64'd0);
    rd(8'h40, v); chk("R2 unmapped", v, 64'd0);
    rd(8'h90, v); chk("R2 valid high", v, 64'd0);

    // R3 bit 0 clear: no start
    wr(8'h08, 64'h2);
    idle(2);
    rd(8'h00, v); chk("R3 no start", v, 64'd0);

    // three-element run, operands ready before the start
    push_pair(32'd5, 32'd10);
    push_pair(32'd7, 32'd8);
    push_pair(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    idle(1);
    chk("R5 idle ready", {62'd0, a_ready, b_ready}, 64'd0);
    wr(8'h08, 64'h1);
    rd(8'h00, v); chk("R3 pulse cycle", v, 64'd0);
    rd(8'h00, v); chk("R3 busy", v, 64'd1);

    // R7 stall while a result is unread
    v = '0;
    while (!v[32]) rd(8'h88, v);
    idle(5);
    chk("R7 stall ready", {63'd0, a_ready}, 64'd0);
    chk("R7 stall queue", 64'(qa.size()), 64'd2);
    rd(8'h88, v); chk("R7 held", v, {31'd0, 1'b1, 32'd0});
    // R4 start ignored mid-run, R12 count change mid-run
    wr(8'h08, 64'h1);
    wr(8'h80, 64'd9);
    rd(8'h80, v); chk("R6 first", {32'd0, v[63:32]}, exp_q.pop_front());
    take("R6 second");
    take("R6 carry");
    idle(2);
    rd(8'h00, v); chk("R8 done", v, 64'd2);
    rd(8'h30, v); chk("R4 single finish", v, 64'd1);
    rd(8'h30, v); chk("R10 cleared", v, 64'd0);
    rd(8'h80, v); chk("R12 readback", {32'd0, v[31:0]}, 64'd9);
    chk("R12 queue drained", 64'(qa.size()), 64'd0);

    // R5 one-sided stream is not consumed
    en_b = 0;
    push_pair(32'd100, 32'd23);
    push_pair(32'd1, 32'd2);
    wr(8'h80, 64'd2);
    wr(8'h08, 64'h1);
    rd(8'h00, v); chk("R8 done held in pulse cycle", v, 64'd2);
    idle(4);
    rd(8'h00, v); chk("R8 done cleared", v, 64'd1);
    chk("R5 a_ready one-sided", {63'd0, a_ready}, 64'd0);
    chk("R5 b_ready one-sided", {63'd0, b_ready}, 64'd1);
    chk("R5 not consumed", 64'(qa.size()), 64'd2);
    en_b = 1;
    take("R6 pair one");
    take("R6 pair two");
    idle(2);
    rd(8'h30, v); chk("R10 count", v, 64'd1);

    // R9 zero count
    wr(8'h80, 64'd0);
    wr(8'h08, 64'h1);
    idle(3);
    rd(8'h00, v); chk("R9 status", v, 64'd2);
    chk("R9 ready", {62'd0, a_ready, b_ready}, 64'd0);
    // R11 completion on the same cycle as a finish read
    wr(8'h08, 64'h1);
    rd(8'h30, v); chk("R11 old value", v, 64'd1);
    rd(8'h30, v); chk("R11 holds one", v, 64'd1);
    rd(8'h30, v); chk("R10 clear", v, 64'd0);

    // 256-element run
    x = 32'h1234_5678;
    for (int i = 0; i < 256; i++) begin
      logic [31:0] p;
      x = x * 32'd1664525 + 32'd1013904223;
      p = x;
      x = x * 32'd1664525 + 32'd1013904223;
      push_pair(p, x);
    end
    wr(8'h80, 64'd256);
    wr(8'h08, 64'h1);
    for (int i = 0; i < 256; i++) take("R6 long run");
    idle(2);
    rd(8'h00, v); chk("R8 long done", v, 64'd2);
    rd(8'h30, v); chk("R10 long finish", v, 64'd1);

    idle(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule